// File: doc/BRIEF.md
# Mirrored Record Commit Controller

This block keeps a record of several words consistent across two memory regions, a main region and a backup region. Two status bits are stored in the same persistent medium as the data: a main-open bit and a mirror-open bit. An update marks the main region as open, writes the new record into it, marks it complete, moves through a transient state, copies main into backup, and finally clears both bits. The order of the status states ensures that exactly one bit changes on each status write.

When reset is released, the controller reads the stored status bits. From those two bits alone it decides which region may hold a torn record, and it repairs that region before it accepts new work. Power can fail at any cycle of an update. After recovery both regions hold the same record: the old record if the main write had not been marked complete, and the new record otherwise. The host sees one `busy` output. A request is taken only while `busy` is low.

Top module: `mirrored_commit`

## Requirements
- R1: `busy` is high while reset is asserted, during the boot cycle and through any recovery. It goes low only when the stored status bits equal 00. No write enable is active while reset is asserted.
- R2: An update request accepted while idle holds `busy` high for exactly 2*WORDS+4 cycles. At the end both regions hold the requested record, and the status bits equal 00. Word i of the record is `upd_data[i*W +: W]`.
- R3: The status bus carries the main-open bit on bit 1 and the mirror-open bit on bit 0. Every status write changes exactly one stored bit. An update goes 00, 10, 11, 01, 00.
- R4: In any cycle, at most one of the three write enables (status, main, backup) is active.
- R5: Main words are written only while the stored main-open bit is 1. Backup words are written only while the stored status equals 01.
- R6: An update request that arrives while `busy` is high is ignored. Neither region ends up with its data, and no second update follows.
- R7: With stored status 00 at reset release, the controller writes nothing and is idle after one boot cycle.
- R8: With stored status 10 at reset release, every backup word is copied into main, and then the status is written to 00.
- R9: With stored status 11 at reset release, the status is written to 01, main is copied into backup, and the status is written to 00. With 01, the copy and the final clear run directly.
- R10: A reset that cuts an update at any cycle leaves, after recovery, identical regions and status 00. The regions hold the old record if the cut came at or before the cycle that writes 11, and the new record otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also models a power loss |
| upd_req | input | 1 | Update request, sampled while idle |
| upd_data | input | WORDS*W | New record, word i at bits i*W +: W |
| busy | output | 1 | Controller is not idle |
| main_addr | output | AW | Main region word address |
| main_we | output | 1 | Main region write enable |
| main_wdata | output | W | Main region write data |
| main_rdata | input | W | Main region read data, combinational from main_addr |
| bak_addr | output | AW | Backup region word address |
| bak_we | output | 1 | Backup region write enable |
| bak_wdata | output | W | Backup region write data |
| bak_rdata | input | W | Backup region read data, combinational from bak_addr |
| stat_we | output | 1 | Status-bit write enable |
| stat_wdata | output | 2 | Status value to store ({main-open, mirror-open}) |
| stat_rdata | input | 2 | Stored status bits |

## Verification
An accepted request shows `busy` at the next falling edge. The update completes 2*WORDS+4 cycles after the accepting edge, so the bench counts `busy` samples at falling edges and compares the count with that figure. Region contents and status bits are compared only after `busy` has fallen. Reset cuts are placed by counting falling edges after acceptance, which fixes which writes have landed, and the expected old or new record follows from that count. Gray stepping, single-write cycles and region write permission are tracked on every rising edge against the stored status bits.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    localparam logic [1:0] STAT_CLEAN     = 2'b00;
    localparam logic [1:0] STAT_COPYING   = 2'b01;
    localparam logic [1:0] STAT_MAIN_OPEN = 2'b10;
    localparam logic [1:0] STAT_MAIN_DONE = 2'b11;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_IDLE,
        ST_MARK_OPEN,
        ST_WR_MAIN,
        ST_MARK_DONE,
        ST_MARK_COPY,
        ST_COPY,
        ST_CLEAR,
        ST_RESTORE,
        ST_RESTORED
    } mrc_state_e;

    typedef struct packed {
        logic       main_we;
        logic       bak_we;
        logic       stat_we;
        logic [1:0] stat_val;
        logic       main_from_bak;
        logic       walk;
    } mrc_ctrl_t;

    function automatic mrc_state_e boot_target(input logic [1:0] stored);
        case (stored)
            STAT_MAIN_OPEN: return ST_RESTORE;
            STAT_MAIN_DONE: return ST_MARK_COPY;
            STAT_COPYING:   return ST_COPY;
            default:        return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/mrc_word_seq.sv
module mrc_word_seq #(
    parameter int WORDS = 4,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          walk,
    output logic [AW-1:0] idx,
    output logic          last
);
    localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

    assign last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || !walk || last) idx <= '0;
        else                      idx <= idx + 1'b1;
    end
endmodule

// File: rtl/mrc_record_hold.sv
module mrc_record_hold #(
    parameter int WORDS = 4,
    parameter int W = 16,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             capture,
    input  logic [WORDS*W-1:0] rec_in,
    input  logic [AW-1:0]    sel,
    output logic [W-1:0]     word
);
    logic [W-1:0] held [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (capture) held[i] <= rec_in[i*W +: W];
        end
    end

    assign word = held[sel];
endmodule

// File: rtl/mrc_fsm.sv
module mrc_fsm
    import mrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic [1:0] stored,
    input  logic       last,
    output mrc_ctrl_t  ctrl,
    output logic       capture,
    output logic       busy
);
    mrc_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_BOOT;
        else     state <= nxt;
    end

    always_comb begin
        nxt     = state;
        ctrl    = '0;
        capture = 1'b0;
        case (state)
            ST_BOOT: nxt = boot_target(stored);
            ST_IDLE: begin
                if (req) begin
                    capture = 1'b1;
                    nxt     = ST_MARK_OPEN;
                end
            end
            ST_MARK_OPEN: begin
                ctrl.stat_we  = 1'b1;
                ctrl.stat_val = STAT_MAIN_OPEN;
                nxt           = ST_WR_MAIN;
            end
            ST_WR_MAIN: begin
                ctrl.main_we = 1'b1;
                ctrl.walk    = 1'b1;
                if (last) nxt = ST_MARK_DONE;
            end
            ST_MARK_DONE: begin
                ctrl.stat_we  = 1'b1;
                ctrl.stat_val = STAT_MAIN_DONE;
                nxt           = ST_MARK_COPY;
            end
            ST_MARK_COPY: begin
                ctrl.stat_we  = 1'b1;
                ctrl.stat_val = STAT_COPYING;
                nxt           = ST_COPY;
            end
            ST_COPY: begin
                ctrl.bak_we = 1'b1;
                ctrl.walk   = 1'b1;
                if (last) nxt = ST_CLEAR;
            end
            ST_RESTORE: begin
                ctrl.main_we       = 1'b1;
                ctrl.main_from_bak = 1'b1;
                ctrl.walk          = 1'b1;
                if (last) nxt = ST_RESTORED;
            end
            ST_CLEAR, ST_RESTORED: begin
                ctrl.stat_we  = 1'b1;
                ctrl.stat_val = STAT_CLEAN;
                nxt           = ST_IDLE;
            end
            default: nxt = ST_BOOT;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/mirrored_commit.sv
module mirrored_commit
    import mrc_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int W = 16,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_req,
    input  logic [WORDS*W-1:0] upd_data,
    output logic               busy,
    output logic [AW-1:0]      main_addr,
    output logic               main_we,
    output logic [W-1:0]       main_wdata,
    input  logic [W-1:0]       main_rdata,
    output logic [AW-1:0]      bak_addr,
    output logic               bak_we,
    output logic [W-1:0]       bak_wdata,
    input  logic [W-1:0]       bak_rdata,
    output logic               stat_we,
    output logic [1:0]         stat_wdata,
    input  logic [1:0]         stat_rdata
);
    mrc_ctrl_t     ctrl;
    logic          capture;
    logic          last;
    logic [AW-1:0] idx;
    logic [W-1:0]  rec_word;

    mrc_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (upd_req),
        .stored  (stat_rdata),
        .last    (last),
        .ctrl    (ctrl),
        .capture (capture),
        .busy    (busy)
    );

    mrc_word_seq #(.WORDS(WORDS)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .walk (ctrl.walk),
        .idx  (idx),
        .last (last)
    );

    mrc_record_hold #(.WORDS(WORDS), .W(W)) u_hold (
        .clk     (clk),
        .capture (capture),
        .rec_in  (upd_data),
        .sel     (idx),
        .word    (rec_word)
    );

    assign main_addr  = idx;
    assign bak_addr   = idx;
    assign main_we    = ctrl.main_we & ~rst;
    assign bak_we     = ctrl.bak_we & ~rst;
    assign stat_we    = ctrl.stat_we & ~rst;
    assign stat_wdata = ctrl.stat_val;
    assign main_wdata = ctrl.main_from_bak ? bak_rdata : rec_word;
    assign bak_wdata  = main_rdata;
endmodule

// File: rtl/mrc_chk.sv
module mrc_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       main_we,
    input logic       bak_we,
    input logic       stat_we,
    input logic [1:0] stat_wdata,
    input logic [1:0] stat_rdata
);
    AST_BOOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> busy);                                              // R1
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (stat_rdata == 2'b00));                                  // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(main_we || bak_we || stat_we));                        // R6
    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        stat_we |-> ($countones(stat_wdata ^ stat_rdata) == 1));           // R3
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_we, bak_we, stat_we}));                             // R4
    AST_MAIN_GUARD: assert property (@(posedge clk) disable iff (rst)
        main_we |-> stat_rdata[1]);                                        // R5
    AST_BAK_GUARD: assert property (@(posedge clk) disable iff (rst)
        bak_we |-> (stat_rdata == 2'b01));                                 // R5
endmodule

bind mirrored_commit mrc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .main_we    (main_we),
    .bak_we     (bak_we),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .stat_rdata (stat_rdata)
);

// File: tb/sim_mirrored_commit.sv
module sim_mirrored_commit;
    localparam int WORDS = 4;
    localparam int W = 16;
    localparam int AW = 2;
    localparam int RW = WORDS * W;
    localparam int UPD_CYCLES = 2 * WORDS + 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          upd_req;
    logic [RW-1:0] upd_data;
    logic          busy;
    logic [AW-1:0] main_addr, bak_addr;
    logic          main_we, bak_we, stat_we;
    logic [W-1:0]  main_wdata, bak_wdata, main_rdata, bak_rdata;
    logic [1:0]    stat_wdata, stat_rdata;

    logic [W-1:0]  main_m [WORDS];
    logic [W-1:0]  bak_m  [WORDS];
    logic [1:0]    stat_m;
    logic          pre_en;
    logic [RW-1:0] pre_main, pre_bak;
    logic [1:0]    pre_stat;

    int errors = 0;
    int checks = 0;
    int gray_bad = 0;
    int multi_bad = 0;
    int guard_bad = 0;

    mirrored_commit #(.WORDS(WORDS), .W(W)) u0 (
        .clk(clk), .rst(rst), .upd_req(upd_req), .upd_data(upd_data), .busy(busy),
        .main_addr(main_addr), .main_we(main_we), .main_wdata(main_wdata), .main_rdata(main_rdata),
        .bak_addr(bak_addr), .bak_we(bak_we), .bak_wdata(bak_wdata), .bak_rdata(bak_rdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata)
    );

    assign main_rdata = main_m[main_addr];
    assign bak_rdata  = bak_m[bak_addr];
    assign stat_rdata = stat_m;

    // persistent storage model, survives reset
    always @(posedge clk) begin
        if (pre_en) begin
            for (int i = 0; i < WORDS; i++) begin
                main_m[i] <= pre_main[i*W +: W];
                bak_m[i]  <= pre_bak[i*W +: W];
            end
            stat_m <= pre_stat;
        end else begin
            if (main_we) main_m[main_addr] <= main_wdata;
            if (bak_we)  bak_m[bak_addr]   <= bak_wdata;
            if (stat_we) stat_m            <= stat_wdata;
            if (stat_we && ($countones(stat_wdata ^ stat_m) != 1)) gray_bad++;
            if ((32'(main_we) + 32'(bak_we) + 32'(stat_we)) > 1) multi_bad++;
            if ((main_we && !stat_m[1]) || (bak_we && stat_m != 2'b01)) guard_bad++;
            if (rst && (main_we || bak_we || stat_we)) guard_bad++;
        end
    end

    function automatic logic [RW-1:0] main_flat();
        logic [RW-1:0] v;
        for (int i = 0; i < WORDS; i++) v[i*W +: W] = main_m[i];
        return v;
    endfunction

    function automatic logic [RW-1:0] bak_flat();
        logic [RW-1:0] v;
        for (int i = 0; i < WORDS; i++) v[i*W +: W] = bak_m[i];
        return v;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [RW-1:0] act,
                         input logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    // hold reset, load storage, release
    task automatic power_cycle(input logic [RW-1:0] m, input logic [RW-1:0] b,
                               input logic [1:0] s);
        @(negedge clk);
        rst = 1'b1; upd_req = 1'b0;
        pre_main = m; pre_bak = b; pre_stat = s; pre_en = 1'b1;
        @(negedge clk);
        pre_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic start_update(input logic [RW-1:0] d);
        upd_data = d; upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
    endtask

    localparam logic [RW-1:0] VEC [4] = '{
        64'h1111_2222_3333_4444,
        64'hFFFF_0000_FFFF_0000,
        64'h0000_0000_0000_0001,
        64'hDEAD_BEEF_CAFE_F00D
    };

    initial begin
        int cnt;
        logic [RW-1:0] prev, nxt;
        rst = 1'b1; upd_req = 1'b0; upd_data = '0; pre_en = 1'b0;
        pre_main = '0; pre_bak = '0; pre_stat = 2'b00;
        @(negedge clk);
        pre_en = 1'b1;
        @(negedge clk);
        pre_en = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R1 busy in reset", RW'(busy), RW'(1));
        check(!(main_we || bak_we || stat_we), "R1 writes in reset",
              RW'({main_we, bak_we, stat_we}), '0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R7 idle after boot from 00", RW'(busy), '0);
        check(main_flat() == '0 && stat_m == 2'b00, "R7 no writes from 00", main_flat(), '0);

        // vector table walk
        for (int v = 0; v < 4; v++) begin
            start_update(VEC[v]);
            wait_idle(cnt);
            check(cnt == UPD_CYCLES, "R2 busy cycle count", RW'(cnt), RW'(UPD_CYCLES));
            check(main_flat() == VEC[v], "R2 main content", main_flat(), VEC[v]);
            check(bak_flat() == VEC[v], "R2 backup content", bak_flat(), VEC[v]);
            check(stat_m == 2'b00, "R2 status clean", RW'(stat_m), '0);
        end

        // request while busy is ignored
        start_update(64'hAAAA_BBBB_CCCC_DDDD);
        @(negedge clk);
        upd_data = 64'h5555_6666_7777_8888; upd_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        upd_req = 1'b0;
        wait_idle(cnt);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R6 no second update", RW'(busy), '0);
        check(main_flat() == 64'hAAAA_BBBB_CCCC_DDDD, "R6 main keeps first record",
              main_flat(), 64'hAAAA_BBBB_CCCC_DDDD);
        check(bak_flat() == 64'hAAAA_BBBB_CCCC_DDDD, "R6 backup keeps first record",
              bak_flat(), 64'hAAAA_BBBB_CCCC_DDDD);

        // boot recovery from each dirty status
        power_cycle(64'h0101_0202_0303_0404, 64'h0A0A_0B0B_0C0C_0D0D, 2'b10);
        @(negedge clk);
        check(busy == 1'b1, "R1 busy during recovery", RW'(busy), RW'(1));
        wait_idle(cnt);
        check(main_flat() == 64'h0A0A_0B0B_0C0C_0D0D, "R8 main restored",
              main_flat(), 64'h0A0A_0B0B_0C0C_0D0D);
        check(stat_m == 2'b00, "R8 status clean", RW'(stat_m), '0);

        power_cycle(64'h1234_5678_9ABC_DEF0, 64'h0A0A_0B0B_0C0C_0D0D, 2'b11);
        wait_idle(cnt);
        check(bak_flat() == 64'h1234_5678_9ABC_DEF0, "R9 backup refreshed from 11",
              bak_flat(), 64'h1234_5678_9ABC_DEF0);
        check(stat_m == 2'b00, "R9 status clean after 11", RW'(stat_m), '0);

        power_cycle(64'h7777_1111_7777_1111, 64'h0A0A_0B0B_0C0C_0D0D, 2'b01);
        wait_idle(cnt);
        check(bak_flat() == 64'h7777_1111_7777_1111, "R9 backup refreshed from 01",
              bak_flat(), 64'h7777_1111_7777_1111);
        check(stat_m == 2'b00, "R9 status clean after 01", RW'(stat_m), '0);

        // cut an update at every cycle
        for (int k = 0; k < UPD_CYCLES; k++) begin
            prev = main_flat();
            nxt  = {4{16'hC000 + 16'(k)}};
            upd_data = nxt; upd_req = 1'b1;
            @(negedge clk);
            upd_req = 1'b0;
            repeat (k) @(negedge clk);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            wait_idle(cnt);
            check(main_flat() == bak_flat(), "R10 regions match", main_flat(), bak_flat());
            check(main_flat() == ((k <= WORDS + 1) ? prev : nxt), "R10 record chosen",
                  main_flat(), (k <= WORDS + 1) ? prev : nxt);
            check(stat_m == 2'b00, "R10 status clean", RW'(stat_m), '0);
        end

        check(gray_bad == 0, "R3 one bit per status write", RW'(gray_bad), '0);
        check(multi_bad == 0, "R4 one write per cycle", RW'(multi_bad), '0);
        check(guard_bad == 0, "R5 region write permission", RW'(guard_bad), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule